// File: doc/BRIEF.md
# Four-Channel Host/Management Mailbox

This block carries single-byte messages between a host processor and a management controller over four independent mailbox channels. Each channel has an inbound data word, an outbound data word and a status word. The status word keeps a full/empty flag for each direction. The host side uses a narrow byte port that selects a channel and one of that channel's three registers. The management controller sees a 4 KB window of 32-bit words that holds the channel registers and the enable and interrupt-enable bits.

Reading or writing a data word changes the matching status flags as a side effect. Two examples: a host write into the inbound word marks it full, and a controller read of that word marks it empty again. Each channel can raise its own interrupt line when inbound data arrives. A separate combined interrupt output reports whether any of a set of subdevice interrupt inputs is active.

Top module: `host_mbox`

## Requirements
- R1: The controller window is addressed in 32-bit words (byte offset divided by 4) with `ctlAddr`. A write stores into the addressed word and a read returns it in the same cycle on `ctlRdata`. Words at or beyond `NUM_WORDS` (default 72) read as zero and are not changed by writes. `ctlReady` is always high.
- R2: Controller writes honour `ctlStrb`, little-endian: strobe bit n enables byte n of the word. Bytes whose strobe is clear keep their old value.
- R3: A host write with `hostSel`=0 (inbound data) stores the byte zero-extended into the channel's inbound word. It also sets bit 1 (inbound full) of that channel's status word. The inbound, outbound and status words are at words 9/12/15, 10/13/16 and 11/14/17 for channels 0 to 2, and at words 69/70/71 for channel 3.
- R4: A controller read of a channel's inbound word clears that channel's status bit 1.
- R5: A controller write of a channel's outbound word sets status bit 0 (outbound full). A host read with `hostSel`=1 returns the outbound byte and clears status bit 0.
- R6: The host can read the low byte of the status word with `hostSel`=2. Host writes with `hostSel`=2 (status) or `hostSel`=1 (outbound) change nothing. Status bit 3 is a command/data flag that only the controller writes.
- R7: Each channel is gated by its own enable: word 0 bit 5 for channel 0 and word 0 bit 6 for channel 1. Channel 2 needs word 0 bit 7 and word 4 bit 2 together. Channel 3 uses word 64 bit 0.
- R8: A host inbound write raises `chanIrq[c]` on the next clock edge only when the channel is enabled and its inbound interrupt enable is set. The interrupt enables are word 2 bits 1, 2 and 3 for channels 0 to 2, and word 64 bit 1 for channel 3.
- R9: A controller read of the inbound word lowers `chanIrq[c]` only if status bit 1 was set at that moment. Otherwise the line keeps its level.
- R10: `irqAny` is high one clock after any bit of `subIrqIn` is high. It follows the OR of those inputs with one register stage.
- R11: Reset clears every word, every channel interrupt and the pending inputs, except word 34 (byte offset 0x88), which takes the parameter `RESET_CFG`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ctlValid | input | 1 | Controller access request |
| ctlWrite | input | 1 | 1 = write, 0 = read |
| ctlAddr | input | 10 | Word address in the 4 KB window |
| ctlWdata | input | 32 | Controller write data |
| ctlStrb | input | 4 | Byte enables for writes |
| ctlReady | output | 1 | Access accepted (always high) |
| ctlRdata | output | 32 | Read data of the addressed word |
| hostWrEn | input | 1 | Host byte write |
| hostRdEn | input | 1 | Host byte read |
| hostChan | input | 2 | Host channel select |
| hostSel | input | 2 | 0 inbound, 1 outbound, 2 status |
| hostWdata | input | 8 | Host write byte |
| hostRdata | output | 8 | Host read byte |
| subIrqIn | input | NUM_SUB | Subdevice interrupt levels |
| chanIrq | output | 4 | Per-channel inbound interrupt |
| irqAny | output | 1 | Combined interrupt |

## Verification
The flag assertions assume a single controller access per cycle. They also assume the controller does not write a status word in the same cycle that the host touches that channel. The stimulus keeps to this by issuing one access per task and never overlapping host and controller traffic. The interrupt checks assume `subIrqIn` is driven only between clock edges. The bench changes it on the falling edge and samples `irqAny` on the falling edges before and after the next rising edge.

// File: rtl/host_mbox_pkg.sv
package host_mbox_pkg;
  localparam int NUM_CHAN = 4;
  localparam int ADDR_W   = 10;   // 4 KB window in 32-bit words
  localparam int HOST_W   = 8;

  // status word flag positions
  localparam int BIT_OBF = 0;
  localparam int BIT_IBF = 1;
  localparam int BIT_CD  = 3;

  // fixed word positions of the control words
  localparam int W_CHEN  = 0;
  localparam int W_IRQEN = 2;
  localparam int W_CH2EN = 4;
  localparam int W_CFG   = 34;
  localparam int W_CH3   = 64;

  // host register selector
  localparam logic [1:0] HSEL_IN   = 2'd0;
  localparam logic [1:0] HSEL_OUT  = 2'd1;
  localparam logic [1:0] HSEL_STAT = 2'd2;

  function automatic int inWord(input int ch);
    return (ch < 3) ? 9 + ch : 69;
  endfunction

  function automatic int outWord(input int ch);
    return (ch < 3) ? 12 + ch : 70;
  endfunction

  function automatic int statWord(input int ch);
    return (ch < 3) ? 15 + ch : 71;
  endfunction

  // strobes from control to datapath
  typedef struct packed {
    logic                ctlWr;
    logic [ADDR_W-1:0]   ctlWord;
    logic [3:0]          ctlStrb;
    logic [31:0]         ctlData;
    logic [HOST_W-1:0]   hostData;
    logic [NUM_CHAN-1:0] setIbf;
    logic [NUM_CHAN-1:0] clrIbf;
    logic [NUM_CHAN-1:0] setObf;
    logic [NUM_CHAN-1:0] clrObf;
  } strobe_t;

  // configuration and flag view from datapath to control
  typedef struct packed {
    logic [NUM_CHAN-1:0] enBit;
    logic                ch2Aux;
    logic [NUM_CHAN-1:0] ieBit;
    logic [NUM_CHAN-1:0] ibf;
    logic [NUM_CHAN-1:0] obf;
  } cfgView_t;
endpackage

// File: rtl/host_mbox_regs.sv
module host_mbox_regs
  import host_mbox_pkg::*;
#(
  parameter int          NUM_WORDS = 72,
  parameter logic [31:0] RESET_CFG = 32'h0
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] rdWord,
  input  logic [1:0]        hostChan,
  input  logic [1:0]        hostSel,
  output logic [31:0]       ctlRdata,
  output logic [HOST_W-1:0] hostRdata,
  output cfgView_t          cfg
);
  localparam int IDX_W = $clog2(NUM_WORDS);

  logic [31:0] mem     [NUM_WORDS];
  logic [31:0] memNext [NUM_WORDS];

  always_comb begin
    for (int w = 0; w < NUM_WORDS; w++) begin
      memNext[w] = mem[w];
      if (stb.ctlWr && (stb.ctlWord == ADDR_W'(w))) begin
        for (int b = 0; b < 4; b++) begin
          if (stb.ctlStrb[b]) memNext[w][8*b +: 8] = stb.ctlData[8*b +: 8];
        end
      end
    end
    for (int c = 0; c < NUM_CHAN; c++) begin
      if (stb.setIbf[c]) memNext[inWord(c)] = {{(32-HOST_W){1'b0}}, stb.hostData};
      if (stb.clrIbf[c]) memNext[statWord(c)][BIT_IBF] = 1'b0;
      if (stb.clrObf[c]) memNext[statWord(c)][BIT_OBF] = 1'b0;
      if (stb.setIbf[c]) memNext[statWord(c)][BIT_IBF] = 1'b1;
      if (stb.setObf[c]) memNext[statWord(c)][BIT_OBF] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int w = 0; w < NUM_WORDS; w++) mem[w] <= (w == W_CFG) ? RESET_CFG : 32'h0;
    end else begin
      for (int w = 0; w < NUM_WORDS; w++) mem[w] <= memNext[w];
    end
  end

  // controller read port
  always_comb begin
    if (int'(rdWord) < NUM_WORDS) ctlRdata = mem[rdWord[IDX_W-1:0]];
    else                          ctlRdata = 32'h0;
  end

  // host read port
  always_comb begin
    case (hostSel)
      HSEL_IN:   hostRdata = mem[inWord(int'(hostChan))][HOST_W-1:0];
      HSEL_OUT:  hostRdata = mem[outWord(int'(hostChan))][HOST_W-1:0];
      HSEL_STAT: hostRdata = mem[statWord(int'(hostChan))][HOST_W-1:0];
      default:   hostRdata = '0;
    endcase
  end

  // configuration view
  assign cfg.enBit[0] = mem[W_CHEN][5];
  assign cfg.enBit[1] = mem[W_CHEN][6];
  assign cfg.enBit[2] = mem[W_CHEN][7];
  assign cfg.enBit[3] = mem[W_CH3][0];
  assign cfg.ch2Aux   = mem[W_CH2EN][2];
  assign cfg.ieBit[0] = mem[W_IRQEN][1];
  assign cfg.ieBit[1] = mem[W_IRQEN][2];
  assign cfg.ieBit[2] = mem[W_IRQEN][3];
  assign cfg.ieBit[3] = mem[W_CH3][1];

  for (genvar c = 0; c < NUM_CHAN; c++) begin : gFlags
    localparam int SW = statWord(c);
    assign cfg.ibf[c] = mem[SW][BIT_IBF];
    assign cfg.obf[c] = mem[SW][BIT_OBF];

    AST_IBF_SET: assert property (@(posedge clk) disable iff (!rstN)
      stb.setIbf[c] |=> cfg.ibf[c]); // R3
    AST_IBF_CLR: assert property (@(posedge clk) disable iff (!rstN)
      (stb.clrIbf[c] && !stb.setIbf[c]) |=> !cfg.ibf[c]); // R4
    AST_OBF_SET: assert property (@(posedge clk) disable iff (!rstN)
      stb.setObf[c] |=> cfg.obf[c]); // R5
    AST_OBF_CLR: assert property (@(posedge clk) disable iff (!rstN)
      (stb.clrObf[c] && !stb.setObf[c] &&
       !(stb.ctlWr && stb.ctlWord == ADDR_W'(SW))) |=> !cfg.obf[c]); // R5
  end
endmodule

// File: rtl/host_mbox_ctrl.sv
module host_mbox_ctrl
  import host_mbox_pkg::*;
#(
  parameter int NUM_WORDS = 72,
  parameter int NUM_SUB   = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                ctlValid,
  input  logic                ctlWrite,
  input  logic [ADDR_W-1:0]   ctlAddr,
  input  logic [31:0]         ctlWdata,
  input  logic [3:0]          ctlStrb,
  output logic                ctlReady,
  input  logic                hostWrEn,
  input  logic                hostRdEn,
  input  logic [1:0]          hostChan,
  input  logic [1:0]          hostSel,
  input  logic [HOST_W-1:0]   hostWdata,
  input  logic [NUM_SUB-1:0]  subIrqIn,
  input  cfgView_t            cfg,
  output strobe_t             stb,
  output logic [NUM_CHAN-1:0] chanIrq,
  output logic                irqAny
);
  logic                inRange;
  logic                ctlRd;
  logic [NUM_CHAN-1:0] chanOn;
  logic [NUM_CHAN-1:0] irqOk;
  logic [NUM_SUB-1:0]  pending;

  assign ctlReady = 1'b1;
  assign inRange  = int'(ctlAddr) < NUM_WORDS;
  assign ctlRd    = ctlValid && !ctlWrite;

  assign stb.ctlWr    = ctlValid && ctlWrite && inRange;
  assign stb.ctlWord  = ctlAddr;
  assign stb.ctlStrb  = ctlStrb;
  assign stb.ctlData  = ctlWdata;
  assign stb.hostData = hostWdata;

  for (genvar c = 0; c < NUM_CHAN; c++) begin : gChan
    if (c == 2) begin : gDual
      assign chanOn[c] = cfg.enBit[c] && cfg.ch2Aux;
    end else begin : gSingle
      assign chanOn[c] = cfg.enBit[c];
    end
    assign irqOk[c] = chanOn[c] && cfg.ieBit[c];

    assign stb.setIbf[c] = hostWrEn && (hostSel == HSEL_IN)  && (hostChan == 2'(c));
    assign stb.clrObf[c] = hostRdEn && (hostSel == HSEL_OUT) && (hostChan == 2'(c));
    assign stb.clrIbf[c] = ctlRd && (ctlAddr == ADDR_W'(inWord(c)));
    assign stb.setObf[c] = stb.ctlWr && (ctlAddr == ADDR_W'(outWord(c)));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                chanIrq[c] <= 1'b0;
      else if (stb.setIbf[c] && irqOk[c])       chanIrq[c] <= 1'b1;
      else if (stb.clrIbf[c] && cfg.ibf[c])     chanIrq[c] <= 1'b0;
    end

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rstN)
      $rose(chanIrq[c]) |-> $past(stb.setIbf[c] && irqOk[c])); // R8
    AST_IRQ_LOWER: assert property (@(posedge clk) disable iff (!rstN)
      $fell(chanIrq[c]) |-> $past(stb.clrIbf[c] && cfg.ibf[c])); // R9
    AST_IRQ_CH_GATE: assert property (@(posedge clk) disable iff (!rstN)
      (stb.setIbf[c] && !chanOn[c] && !chanIrq[c]) |=> !chanIrq[c]); // R7
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pending <= '0;
    else       pending <= subIrqIn;
  end
  assign irqAny = |pending;

  AST_ANY_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    irqAny |-> $past(|subIrqIn)); // R10
  AST_HOST_ONE_CHAN: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb.setIbf | stb.clrObf)); // R6
endmodule

// File: rtl/host_mbox.sv
module host_mbox
  import host_mbox_pkg::*;
#(
  parameter int          NUM_WORDS = 72,
  parameter int          NUM_SUB   = 5,
  parameter logic [31:0] RESET_CFG = 32'h0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               ctlValid,
  input  logic               ctlWrite,
  input  logic [9:0]         ctlAddr,
  input  logic [31:0]        ctlWdata,
  input  logic [3:0]         ctlStrb,
  output logic               ctlReady,
  output logic [31:0]        ctlRdata,
  input  logic               hostWrEn,
  input  logic               hostRdEn,
  input  logic [1:0]         hostChan,
  input  logic [1:0]         hostSel,
  input  logic [7:0]         hostWdata,
  output logic [7:0]         hostRdata,
  input  logic [NUM_SUB-1:0] subIrqIn,
  output logic [3:0]         chanIrq,
  output logic               irqAny
);
  strobe_t  stb;
  cfgView_t cfg;

  host_mbox_ctrl #(.NUM_WORDS(NUM_WORDS), .NUM_SUB(NUM_SUB)) uCtrl (
    .clk(clk), .rstN(rstN),
    .ctlValid(ctlValid), .ctlWrite(ctlWrite), .ctlAddr(ctlAddr),
    .ctlWdata(ctlWdata), .ctlStrb(ctlStrb), .ctlReady(ctlReady),
    .hostWrEn(hostWrEn), .hostRdEn(hostRdEn), .hostChan(hostChan),
    .hostSel(hostSel), .hostWdata(hostWdata),
    .subIrqIn(subIrqIn), .cfg(cfg), .stb(stb),
    .chanIrq(chanIrq), .irqAny(irqAny)
  );

  host_mbox_regs #(.NUM_WORDS(NUM_WORDS), .RESET_CFG(RESET_CFG)) uRegs (
    .clk(clk), .rstN(rstN), .stb(stb), .rdWord(ctlAddr),
    .hostChan(hostChan), .hostSel(hostSel),
    .ctlRdata(ctlRdata), .hostRdata(hostRdata), .cfg(cfg)
  );
endmodule

// File: tb/tb_host_mbox.sv
`timescale 1ns/1ps
module tb_host_mbox;
  localparam logic [31:0] CFG_INIT = 32'h1234_ABCD;
  localparam int          NSUB     = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ctlValid = 0, ctlWrite = 0;
  logic [9:0] ctlAddr = '0;
  logic [31:0] ctlWdata = '0;
  logic [3:0] ctlStrb = '0;
  logic ctlReady;
  logic [31:0] ctlRdata;
  logic hostWrEn = 0, hostRdEn = 0;
  logic [1:0] hostChan = '0, hostSel = '0;
  logic [7:0] hostWdata = '0;
  logic [7:0] hostRdata;
  logic [NSUB-1:0] subIrqIn = '0;
  logic [3:0] chanIrq;
  logic irqAny;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  host_mbox #(.NUM_WORDS(72), .NUM_SUB(NSUB), .RESET_CFG(CFG_INIT)) dut (
    .clk(clk), .rstN(rstN), .ctlValid(ctlValid), .ctlWrite(ctlWrite),
    .ctlAddr(ctlAddr), .ctlWdata(ctlWdata), .ctlStrb(ctlStrb),
    .ctlReady(ctlReady), .ctlRdata(ctlRdata), .hostWrEn(hostWrEn),
    .hostRdEn(hostRdEn), .hostChan(hostChan), .hostSel(hostSel),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .subIrqIn(subIrqIn),
    .chanIrq(chanIrq), .irqAny(irqAny)
  );

  typedef struct packed {
    logic        isWr;
    logic [9:0]  addr;
    logic [31:0] data;
    logic [3:0]  strb;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NVEC = 11;
  localparam vec_t VEC [NVEC] = '{
    '{1'b0, 10'd34,   32'h0,         4'h0, CFG_INIT,      8'd11}, // R11
    '{1'b1, 10'd1,    32'hA5A5_A5A5, 4'hF, 32'h0,         8'd1},  // R1
    '{1'b0, 10'd1,    32'h0,         4'h0, 32'hA5A5_A5A5, 8'd1},  // R1
    '{1'b1, 10'd1,    32'h1122_3344, 4'h5, 32'h0,         8'd2},  // R2
    '{1'b0, 10'd1,    32'h0,         4'h0, 32'hA522_A544, 8'd2},  // R2
    '{1'b1, 10'd1023, 32'hDEAD_BEEF, 4'hF, 32'h0,         8'd1},  // R1
    '{1'b0, 10'd1023, 32'h0,         4'h0, 32'h0,         8'd1},  // R1
    '{1'b1, 10'd72,   32'hCAFE_F00D, 4'hF, 32'h0,         8'd1},  // R1
    '{1'b0, 10'd72,   32'h0,         4'h0, 32'h0,         8'd1},  // R1
    '{1'b1, 10'd35,   32'h7777_77FF, 4'h1, 32'h0,         8'd2},  // R2
    '{1'b0, 10'd35,   32'h0,         4'h0, 32'h0000_00FF, 8'd2}   // R2
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic ctlWr(input int addr, input logic [31:0] d, input logic [3:0] s);
    @(negedge clk);
    ctlValid = 1; ctlWrite = 1; ctlAddr = 10'(addr); ctlWdata = d; ctlStrb = s;
    @(negedge clk);
    ctlValid = 0; ctlWrite = 0; ctlStrb = '0;
  endtask

  task automatic ctlRd(input int addr, output logic [31:0] d);
    @(negedge clk);
    ctlValid = 1; ctlWrite = 0; ctlAddr = 10'(addr);
    #1 d = ctlRdata;
    @(negedge clk);
    ctlValid = 0;
  endtask

  task automatic hostWr(input int ch, input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    hostWrEn = 1; hostChan = 2'(ch); hostSel = sel; hostWdata = d;
    @(negedge clk);
    hostWrEn = 0;
  endtask

  task automatic hostRd(input int ch, input logic [1:0] sel, output logic [7:0] d);
    @(negedge clk);
    hostRdEn = 1; hostChan = 2'(ch); hostSel = sel;
    #1 d = hostRdata;
    @(negedge clk);
    hostRdEn = 0;
  endtask

  initial begin : watchdog
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] r;
    logic [7:0]  h;
    repeat (3) @(negedge clk);
    rstN = 1;

    // reset state, R11
    chk("R11 ready", {31'b0, ctlReady}, 32'h1);
    chk("R11 chanIrq", {28'b0, chanIrq}, 32'h0);
    chk("R11 irqAny", {31'b0, irqAny}, 32'h0);
    ctlRd(0, r);  chk("R11 word0", r, 32'h0);
    ctlRd(15, r); chk("R11 status0", r, 32'h0);

    // table walk: R1, R2, R11
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i].isWr) ctlWr(int'(VEC[i].addr), VEC[i].data, VEC[i].strb);
      else begin
        ctlRd(int'(VEC[i].addr), r);
        chk($sformatf("R%0d vec%0d", VEC[i].req, i), r, VEC[i].exp);
      end
    end

    // channel 0 inbound path: R3 R4 R8 R9
    ctlWr(0, 32'h20, 4'hF);
    ctlWr(2, 32'h02, 4'hF);
    hostWr(0, 2'd0, 8'h5A);
    chk("R8 ch0 irq raised", {28'b0, chanIrq}, 32'h1);
    ctlRd(15, r); chk("R3 ch0 ibf", r, 32'h2);
    hostRd(0, 2'd2, h); chk("R6 host status read", {24'b0, h}, 32'h2);
    ctlRd(9, r); chk("R3 ch0 data", r, 32'h5A);
    chk("R9 ch0 irq lowered", {28'b0, chanIrq}, 32'h0);
    ctlRd(15, r); chk("R4 ch0 ibf clear", r, 32'h0);

    // R9: read with flag already clear keeps line
    hostWr(0, 2'd0, 8'h11);
    ctlWr(15, 32'h0, 4'hF);
    ctlRd(9, r); chk("R3 ch0 data2", r, 32'h11);
    chk("R9 irq kept", {28'b0, chanIrq}, 32'h1);
    hostWr(0, 2'd0, 8'h22);
    ctlRd(9, r);
    chk("R9 irq lowered2", {28'b0, chanIrq}, 32'h0);

    // channel 1 without interrupt enable: R8
    ctlWr(0, 32'h60, 4'hF);
    hostWr(1, 2'd0, 8'h33);
    chk("R8 ch1 no irq", {28'b0, chanIrq}, 32'h0);
    ctlRd(16, r); chk("R3 ch1 ibf", r, 32'h2);
    ctlRd(10, r);

    // outbound path: R5
    ctlWr(13, 32'h77, 4'hF);
    ctlRd(16, r); chk("R5 obf set", r, 32'h1);
    hostRd(1, 2'd1, h); chk("R5 host out data", {24'b0, h}, 32'h77);
    ctlRd(16, r); chk("R5 obf clear", r, 32'h0);

    // host writes to status/outbound ignored: R6
    hostWr(1, 2'd2, 8'hFF);
    ctlRd(16, r); chk("R6 status unchanged", r, 32'h0);
    hostWr(1, 2'd1, 8'h99);
    ctlRd(13, r); chk("R6 outbound unchanged", r, 32'h77);

    // channel 2 dual enable: R7
    ctlWr(0, 32'hE0, 4'hF);
    ctlWr(2, 32'h0A, 4'hF);
    hostWr(2, 2'd0, 8'h44);
    chk("R7 ch2 half enable", {28'b0, chanIrq}, 32'h0);
    ctlRd(11, r);
    ctlWr(4, 32'h04, 4'hF);
    hostWr(2, 2'd0, 8'h45);
    chk("R7 ch2 full enable", {28'b0, chanIrq}, 32'h4);
    ctlRd(11, r); chk("R3 ch2 data", r, 32'h45);
    chk("R9 ch2 lowered", {28'b0, chanIrq}, 32'h0);

    // channel 3: R7 R8 R9
    hostWr(3, 2'd0, 8'h66);
    chk("R7 ch3 disabled", {28'b0, chanIrq}, 32'h0);
    ctlRd(71, r); chk("R3 ch3 ibf", r, 32'h2);
    ctlRd(69, r);
    ctlWr(64, 32'h3, 4'hF);
    hostWr(3, 2'd0, 8'h67);
    chk("R8 ch3 irq", {28'b0, chanIrq}, 32'h8);
    ctlRd(69, r); chk("R3 ch3 data", r, 32'h67);
    chk("R9 ch3 lowered", {28'b0, chanIrq}, 32'h0);

    // combined interrupt: R10
    @(negedge clk);
    subIrqIn = 5'b00100;
    #1 chk("R10 not yet", {31'b0, irqAny}, 32'h0);
    @(negedge clk);
    chk("R10 raised", {31'b0, irqAny}, 32'h1);
    subIrqIn = '0;
    @(negedge clk);
    chk("R10 cleared", {31'b0, irqAny}, 32'h0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule